// File: doc/BRIEF.md
# Aligned Power-of-Two Clock Ratio Generator

This block produces three clock-enable strobes for a CPU domain, an AXI domain and an AHB/APB peripheral-bus domain, all derived from one master clock. Each domain runs at the master rate divided by 1, 2, 4 or 8. A 6-bit settings word written through a simple write port selects the three ratios. Every strobe comes from one shared 3-bit phase counter, so the strobes stay edge aligned: whenever a slower domain's strobe is high, every faster domain's strobe is high in the same cycle.

A written word is held as pending and moves to the active setting only when the phase counter wraps. Because of this, no domain ever sees a shortened period when the ratios change. The peripheral-bus domain may not run at the full master rate. A request for that rate is raised to divide-by-2, and an error flag records the substitution. After reset all three domains run at divide-by-8.

Top module: `ckdiv_sync_div`

## Requirements
- R1: After reset the active setting reads 0x3F, the error flag is low, and every strobe pulses once per 8 master cycles.
- R2: Setting bits [1:0] select the CPU ratio, bits [3:2] the AXI ratio and bits [5:4] the peripheral-bus ratio.
- R3: Each 2-bit code selects the division ratio 2^code: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. A strobe at ratio N is high in exactly one cycle of every N.
- R4: A write whose bits [5:4] are 00 stores 01 in that field, so the bus runs at /2. The error flag reads 1 in the cycle after that write. The active bus field is never 00.
- R5: A write whose bits [5:4] are not 00 clears the error flag in the next cycle. Without a write, the flag holds its value.
- R6: In any cycle, if the strobe of a domain with ratio N is high, the strobe of every domain with ratio N or less is also high.
- R7: The active setting changes only on the first cycle of a counter frame, which is the cycle after the counter reaches 7. Until then, writes have no effect on the strobes.
- R8: The gap between two strobes of a domain, or from reset to its first strobe, always equals that domain's active ratio, including across a ratio change.
- R9: When several writes land in one counter frame, only the last one becomes active, and earlier values never appear on the active setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Write strobe for the settings word |
| cfg_wdata_i | input | 6 | Settings word: [5:4] bus, [3:2] AXI, [1:0] CPU ratio codes |
| cpu_en_o | output | 1 | CPU domain clock enable |
| axi_en_o | output | 1 | AXI domain clock enable |
| bus_en_o | output | 1 | Peripheral-bus domain clock enable |
| cfg_active_o | output | 6 | Setting currently applied to the strobes |
| cfg_err_o | output | 1 | Last write requested the forbidden bus ratio |

## Verification
A wrong phase count or a mis-decoded field shows up at the strobe ports within one 8-cycle frame. It appears as a strobe count per frame that does not match the setting, or as a slower strobe firing without a faster one. A ratio that switches outside a frame boundary changes the active setting on some cycle other than the frame's first, and it produces a strobe gap that differs from both the old and the new ratio. A broken coercion path shows on the error flag in the cycle after the write, and on the active bus field one frame later.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
    // Width of one ratio code field
    localparam int FIELD_W = 2;
    // Number of clock domains served
    localparam int DOMAINS = 3;
    // Full settings word
    localparam int CFG_W   = FIELD_W * DOMAINS;
    // Counter spans the largest ratio: 2^(2^FIELD_W - 1)
    localparam int CNT_W   = (1 << FIELD_W) - 1;

    // Domain slot indices; the slot order fixes the field position in the word
    localparam int DOM_CPU = 0;
    localparam int DOM_AXI = 1;
    localparam int DOM_BUS = 2;

    typedef logic [CFG_W-1:0]   cfg_word_t;
    typedef logic [FIELD_W-1:0] ratio_code_t;
    typedef logic [CNT_W-1:0]   phase_t;
endpackage

// File: rtl/ckdiv_cfg_port.sv
module ckdiv_cfg_port
    import ckdiv_pkg::*;
#(
    parameter cfg_word_t   RESET_CFG  = '1,
    parameter ratio_code_t FLOOR_CODE = ratio_code_t'(1),
    parameter int          FLOOR_DOM  = DOM_BUS
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      we_i,
    input  cfg_word_t wdata_i,
    output cfg_word_t pend_o,
    output logic      err_o
);
    localparam int FLOOR_LSB = FLOOR_DOM * FIELD_W;

    typedef struct packed {
        cfg_word_t pend;
        logic      err;
    } port_state_t;

    port_state_t s_d, s_q;

    always_comb begin
        cfg_word_t   word;
        ratio_code_t fld;
        s_d  = s_q;
        word = wdata_i;
        fld  = wdata_i[FLOOR_LSB +: FIELD_W];
        if (we_i) begin
            // Raise a too-fast request for the floored domain to its floor
            if (fld < FLOOR_CODE) begin
                word[FLOOR_LSB +: FIELD_W] = FLOOR_CODE;
                s_d.err = 1'b1;
            end else begin
                s_d.err = 1'b0;
            end
            s_d.pend = word;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.pend <= RESET_CFG;
            s_q.err  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;
    assign err_o  = s_q.err;
endmodule

// File: rtl/ckdiv_phase_ctr.sv
module ckdiv_phase_ctr
    import ckdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    output phase_t phase_o,
    output logic   wrap_o
);
    typedef struct packed {
        phase_t phase;
    } ctr_state_t;

    ctr_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.phase = s_q.phase + phase_t'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.phase <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;
    // Last cycle of a frame: every ratio ends a period here
    assign wrap_o  = &s_q.phase;
endmodule

// File: rtl/ckdiv_strobe_dec.sv
module ckdiv_strobe_dec
    import ckdiv_pkg::*;
(
    input  cfg_word_t          act_i,
    input  phase_t             phase_i,
    output logic [DOMAINS-1:0] en_o
);
    for (genvar d = 0; d < DOMAINS; d++) begin : g_dom
        ratio_code_t code;
        phase_t      mask;
        always_comb begin
            code = act_i[d*FIELD_W +: FIELD_W];
            // (1 << code) - 1; the top code wraps to zero and yields all ones
            mask = (phase_t'(1) << code) - phase_t'(1);
            // Strobe on the last phase of each period
            en_o[d] = ((phase_i & mask) == mask);
        end
    end
endmodule

// File: rtl/ckdiv_sync_div.sv
module ckdiv_sync_div
    import ckdiv_pkg::*;
#(
    parameter cfg_word_t   RESET_CFG     = '1,
    parameter ratio_code_t BUS_MIN_CODE  = ratio_code_t'(1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             cpu_en_o,
    output logic             axi_en_o,
    output logic             bus_en_o,
    output logic [CFG_W-1:0] cfg_active_o,
    output logic             cfg_err_o
);
    typedef struct packed {
        cfg_word_t act;
    } top_state_t;

    top_state_t         s_d, s_q;
    cfg_word_t          pend;
    phase_t             phase;
    logic               wrap;
    logic [DOMAINS-1:0] en;

    ckdiv_cfg_port #(
        .RESET_CFG (RESET_CFG),
        .FLOOR_CODE(BUS_MIN_CODE),
        .FLOOR_DOM (DOM_BUS)
    ) i_cfg_port (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (cfg_we_i),
        .wdata_i(cfg_wdata_i),
        .pend_o (pend),
        .err_o  (cfg_err_o)
    );

    ckdiv_phase_ctr i_phase_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .phase_o(phase),
        .wrap_o (wrap)
    );

    // Pending setting moves to active only at a frame boundary
    always_comb begin
        s_d = s_q;
        if (wrap) begin
            s_d.act = pend;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.act <= RESET_CFG;
        end else begin
            s_q <= s_d;
        end
    end

    ckdiv_strobe_dec i_strobe_dec (
        .act_i  (s_q.act),
        .phase_i(phase),
        .en_o   (en)
    );

    assign cpu_en_o     = en[DOM_CPU];
    assign axi_en_o     = en[DOM_AXI];
    assign bus_en_o     = en[DOM_BUS];
    assign cfg_active_o = s_q.act;
endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk
    import ckdiv_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cfg_we_i,
    input logic [CFG_W-1:0] cfg_wdata_i,
    input logic             cpu_en_o,
    input logic             axi_en_o,
    input logic             bus_en_o,
    input logic [CFG_W-1:0] cfg_active_o,
    input logic             cfg_err_o
);
    logic [DOMAINS-1:0] en;
    logic [3:0]         ratio [DOMAINS];
    logic [3:0]         gap_q [DOMAINS];
    phase_t             frm_q;

    assign en[DOM_CPU] = cpu_en_o;
    assign en[DOM_AXI] = axi_en_o;
    assign en[DOM_BUS] = bus_en_o;

    // Independent frame position, counted from reset release
    always_ff @(posedge clk_i) begin
        if (!rst_ni) frm_q <= '0;
        else         frm_q <= frm_q + phase_t'(1);
    end

    for (genvar d = 0; d < DOMAINS; d++) begin : g_gap
        always_comb ratio[d] = 4'(1) << cfg_active_o[d*FIELD_W +: FIELD_W];

        always_ff @(posedge clk_i) begin
            if (!rst_ni)    gap_q[d] <= '0;
            else if (en[d]) gap_q[d] <= '0;
            else            gap_q[d] <= gap_q[d] + 4'd1;
        end

        // R8
        gap_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            en[d] |-> (gap_q[d] + 4'd1) == ratio[d]);
        // R8
        gap_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en[d] |-> (gap_q[d] + 4'd1) < ratio[d]);

        for (genvar e = 0; e < DOMAINS; e++) begin : g_pair
            if (e != d) begin : g_ne
                // R6
                align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (en[d] && ratio[d] >= ratio[e]) |-> en[e]);
            end
        end
    end

    // R7
    frame_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_active_o != $past(cfg_active_o)) |-> frm_q == '0);

    // R4
    bus_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_active_o[DOM_BUS*FIELD_W +: FIELD_W] != '0);

    // R4
    err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_wdata_i[DOM_BUS*FIELD_W +: FIELD_W] == '0) |=> cfg_err_o);

    // R5
    err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_wdata_i[DOM_BUS*FIELD_W +: FIELD_W] != '0) |=> !cfg_err_o);

    // R5
    err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_we_i |=> $stable(cfg_err_o));
endmodule

bind ckdiv_sync_div ckdiv_chk i_ckdiv_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cpu_en_o    (cpu_en_o),
    .axi_en_o    (axi_en_o),
    .bus_en_o    (bus_en_o),
    .cfg_active_o(cfg_active_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/test_ckdiv_sync_div.sv
`timescale 1ns/1ps
module test_ckdiv_sync_div;
    localparam real CLK_PERIOD = 8.0;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [5:0] cfg_wdata_i = '0;
    logic       cpu_en_o, axi_en_o, bus_en_o, cfg_err_o;
    logic [5:0] cfg_active_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    ckdiv_sync_div i_ckdiv_sync_div (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_we_i    (cfg_we_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cpu_en_o    (cpu_en_o),
        .axi_en_o    (axi_en_o),
        .bus_en_o    (bus_en_o),
        .cfg_active_o(cfg_active_o),
        .cfg_err_o   (cfg_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobes per 16 cycles for the field of domain d: 16 / 2^code
    function automatic int per16(input logic [5:0] c, input int d);
        return 16 >> c[d*2 +: 2];
    endfunction

    // Called just after a falling edge; returns at the falling edge after the write
    task automatic do_write(input logic [5:0] data);
        cfg_we_i    = 1'b1;
        cfg_wdata_i = data;
        @(negedge clk_i);
        cfg_we_i    = 1'b0;
    endtask

    task automatic wait_active(input logic [5:0] exp, input string req);
        for (int i = 0; i < 20; i++) begin
            if (cfg_active_o == exp) break;
            @(negedge clk_i);
        end
        chk(cfg_active_o == exp, req, cfg_active_o, exp);
    endtask

    // Starts on the first cycle of a frame; samples 16 cycles
    task automatic measure(input logic [5:0] c, input string req);
        int n_cpu = 0, n_axi = 0, n_bus = 0, bad = 0;
        int r_cpu, r_axi, r_bus;
        r_cpu = 1 << c[1:0];
        r_axi = 1 << c[3:2];
        r_bus = 1 << c[5:4];
        for (int i = 0; i < 16; i++) begin
            n_cpu += cpu_en_o;
            n_axi += axi_en_o;
            n_bus += bus_en_o;
            // R6: slower strobe high implies faster strobe high
            if (cpu_en_o && r_cpu >= r_axi && !axi_en_o) bad++;
            if (cpu_en_o && r_cpu >= r_bus && !bus_en_o) bad++;
            if (axi_en_o && r_axi >= r_cpu && !cpu_en_o) bad++;
            if (axi_en_o && r_axi >= r_bus && !bus_en_o) bad++;
            if (bus_en_o && r_bus >= r_cpu && !cpu_en_o) bad++;
            if (bus_en_o && r_bus >= r_axi && !axi_en_o) bad++;
            @(negedge clk_i);
        end
        chk(n_cpu == per16(c, 0), {req, " R3 cpu"}, n_cpu, per16(c, 0));
        chk(n_axi == per16(c, 1), {req, " R3 axi"}, n_axi, per16(c, 1));
        chk(n_bus == per16(c, 2), {req, " R3 bus"}, n_bus, per16(c, 2));
        chk(bad == 0, "R6 alignment", bad, 0);
    endtask

    task automatic t_reset();
        chk(cfg_active_o == 6'h3F, "R1 active", cfg_active_o, 6'h3F);
        chk(cfg_err_o == 1'b0, "R1 err", cfg_err_o, 0);
        measure(6'h3F, "R1");
    endtask

    task automatic t_ratio(input logic [5:0] c);
        do_write(c);
        chk(cfg_err_o == 1'b0, "R5 err on legal write", cfg_err_o, 0);
        wait_active(c, "R2 active");
        measure(c, "R2");
    endtask

    task automatic t_coerce();
        do_write(6'h0C);
        chk(cfg_err_o == 1'b1, "R4 err set", cfg_err_o, 1);
        wait_active(6'h1C, "R4 coerced");
        measure(6'h1C, "R4");
        do_write(6'h3F);
        chk(cfg_err_o == 1'b0, "R5 err clear", cfg_err_o, 0);
        wait_active(6'h3F, "R5 active");
    endtask

    task automatic t_frame_switch();
        int early = 0;
        // All ratios are /8: the CPU strobe marks the last frame cycle
        for (int i = 0; i < 20; i++) begin
            if (cpu_en_o) break;
            @(negedge clk_i);
        end
        do_write(6'h24);
        chk(cfg_active_o == 6'h3F, "R7 held at frame start", cfg_active_o, 6'h3F);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_i);
            early += cpu_en_o;
        end
        chk(early == 0, "R7 old ratio kept", early, 0);
        @(negedge clk_i);
        chk(cfg_active_o == 6'h3F, "R7 held at frame end", cfg_active_o, 6'h3F);
        @(negedge clk_i);
        chk(cfg_active_o == 6'h24, "R7 switched", cfg_active_o, 6'h24);
        chk(cpu_en_o == 1'b1, "R8 cpu /1 after switch", cpu_en_o, 1);
        chk(axi_en_o == 1'b0, "R8 axi no early strobe", axi_en_o, 0);
        @(negedge clk_i);
        chk(axi_en_o == 1'b1, "R8 axi full period", axi_en_o, 1);
    endtask

    task automatic t_last_wins();
        int seen_first = 0;
        do_write(6'h15);
        do_write(6'h2A);
        for (int i = 0; i < 20; i++) begin
            if (cfg_active_o == 6'h15) seen_first++;
            if (cfg_active_o == 6'h2A) break;
            @(negedge clk_i);
        end
        chk(seen_first == 0, "R9 earlier write hidden", seen_first, 0);
        chk(cfg_active_o == 6'h2A, "R9 last write active", cfg_active_o, 6'h2A);
        measure(6'h2A, "R9");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog ALL actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_ratio(6'h24);
        t_ratio(6'h1B);
        t_ratio(6'h39);
        t_coerce();
        t_frame_switch();
        t_last_wins();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule